// File: doc/BRIEF.md
# Two-Lane Quarter-Rate Quadrature Down-Mixer

This block shifts a real signal down by one quarter of its sample rate. The real stream arrives already split into two parallel lanes, one word per lane per clock. Lane A carries the even-indexed samples and lane B carries the odd-indexed samples, so the block handles two real samples per clock. Within any one clock, the lane A word comes first in stream order.

At a quarter of the sample rate the local oscillator only takes the values +1, 0 and -1. The even samples meet only the cosine term, and the odd samples meet only the sine term. Each lane therefore needs nothing more than a per-sample sign choice. Lane A becomes the in-phase (I) leg and lane B becomes the quadrature (Q) leg.

A one-bit phase tracker advances on every valid input. A sync pulse forces the zero-degree cosine phase onto the lane A word that is present in the same cycle. Both legs then pass through equal-length alignment delays, so each I/Q pair leaves the block together, a fixed number of cycles after it entered.

Top module: `mix4_quad_downmix`

## Requirements
- R1: While `rst` is high, and on the first sampling point after it, `i_valid`, `q_valid`, `i_data` and `q_data` are all zero.
- R2: The I leg multiplies lane A by +1 when the oscillator phase bit is 0 (zero degrees) and by -1 when it is 1 (180 degrees).
- R3: The Q leg multiplies lane B by -1 when the phase bit is 0 (90 degrees) and by +1 when it is 1 (270 degrees).
- R4: After reset the phase bit starts at 0. It inverts after every cycle with `in_valid` high, and it holds over cycles with `in_valid` low.
- R5: When `sync` is high, the current cycle uses phase bit 0, whether or not the bit held another value. The bit then advances from 0 according to R4, and this includes a sync cycle that has `in_valid` low.
- R6: Negation is two's complement. The one exception is that negating -32768 gives +32767.
- R7: A valid input produces `i_valid` and `q_valid` exactly `LATENCY` clock edges later (4 by default), carrying that input's mixed values.
- R8: `i_valid` and `q_valid` are always equal. The I and Q results of one input cycle appear in the same output cycle.
- R9: An output cycle whose valid flag is low carries zero data, whatever was on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Both lane words are valid this cycle |
| sync | input | 1 | Pin the zero-degree phase to this cycle's lane A word |
| lane_a | input | 16 | Even-indexed real sample, signed |
| lane_b | input | 16 | Odd-indexed real sample, signed |
| i_valid | output | 1 | I output valid |
| i_data | output | 16 | Mixed in-phase word, signed |
| q_valid | output | 1 | Q output valid |
| q_data | output | 16 | Mixed quadrature word, signed |

## Verification
The hardest situations to reach are those where sync and the phase bit disagree. One is a sync arriving when the tracker already holds the 180-degree phase. Another is a sync on a cycle with no valid input, which must still re-pin the phase that the next valid word uses. The stimulus places directed sync pulses after odd and even runs of valid words, around gaps, and on back-to-back cycles. It then adds a long sequence with random gaps and random syncs. The most negative input value is driven in both phases on both lanes, so that saturating negation is exercised on each leg.

// File: rtl/mix4_pkg.sv
package mix4_pkg;

    localparam int SAMPLE_W = 16;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    localparam sample_t SAMPLE_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t SAMPLE_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // Phase bit: PH_EVEN covers 0 deg (lane A) / 90 deg (lane B),
    // PH_ODD covers 180 deg (lane A) / 270 deg (lane B).
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } lo_phase_e;

    typedef enum logic {
        LEG_COS = 1'b0,
        LEG_SIN = 1'b1
    } leg_kind_e;

    typedef struct packed {
        logic    vld;
        sample_t dat;
    } leg_word_t;

    function automatic sample_t neg_sat(sample_t x);
        if (x == SAMPLE_MIN) begin
            return SAMPLE_MAX;
        end
        return -x;
    endfunction

    // Cosine leg: +1,-1,... ; sine leg: -1,+1,...
    function automatic logic needs_flip(leg_kind_e kind, lo_phase_e ph);
        if (kind == LEG_COS) begin
            return (ph == PH_ODD);
        end
        return (ph == PH_EVEN);
    endfunction

endpackage

// File: rtl/mix4_phase_track.sv
module mix4_phase_track
    import mix4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      sync,
    output lo_phase_e cur_phase
);

    lo_phase_e ph_q;

    assign cur_phase = sync ? PH_EVEN : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_EVEN;
        end else if (in_valid) begin
            ph_q <= (cur_phase == PH_EVEN) ? PH_ODD : PH_EVEN;
        end else begin
            ph_q <= cur_phase;
        end
    end

    // R5: a sync cycle leaves the bit at 0, or at 1 if it consumed a word
    a_r5_sync_pins_phase: assert property (@(posedge clk) disable iff (rst)
        sync |=> (ph_q == ($past(in_valid) ? PH_ODD : PH_EVEN)));

    // R4: every valid word without sync advances the phase
    a_r4_valid_toggles: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sync) |=> (ph_q != $past(ph_q)));

    // R4: idle cycles without sync keep the phase
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !sync) |=> $stable(ph_q));

endmodule

// File: rtl/mix4_sign_leg.sv
module mix4_sign_leg
    import mix4_pkg::*;
#(
    parameter leg_kind_e KIND = LEG_COS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  sample_t   sample,
    input  lo_phase_e phase,
    output leg_word_t out_w
);

    logic    flip;
    sample_t mixed;

    assign flip  = needs_flip(KIND, phase);
    assign mixed = flip ? neg_sat(sample) : sample;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_w <= '0;
        end else begin
            out_w.vld <= in_valid;
            out_w.dat <= in_valid ? mixed : '0;
        end
    end

    // R6: the most negative input saturates when it is negated
    a_r6_neg_saturates: assert property (@(posedge clk) disable iff (rst)
        (in_valid && flip && sample == SAMPLE_MIN) |=> (out_w.dat == SAMPLE_MAX));

    // R9: an empty slot carries zero data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (out_w.dat == '0));

endmodule

// File: rtl/mix4_align_delay.sv
module mix4_align_delay
    import mix4_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  leg_word_t din,
    output leg_word_t dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_shift
            leg_word_t stage [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < DEPTH; k++) begin
                        stage[k] <= '0;
                    end
                end else begin
                    stage[0] <= din;
                    for (int k = 1; k < DEPTH; k++) begin
                        stage[k] <= stage[k-1];
                    end
                end
            end

            assign dout = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/mix4_quad_downmix.sv
module mix4_quad_downmix
    import mix4_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic                             sync,
    input  logic signed [mix4_pkg::SAMPLE_W-1:0] lane_a,
    input  logic signed [mix4_pkg::SAMPLE_W-1:0] lane_b,
    output logic                             i_valid,
    output logic signed [mix4_pkg::SAMPLE_W-1:0] i_data,
    output logic                             q_valid,
    output logic signed [mix4_pkg::SAMPLE_W-1:0] q_data
);

    localparam int MIX_STAGES = 1;
    localparam int ALIGN_D    = (LATENCY > MIX_STAGES) ? LATENCY - MIX_STAGES : 0;

    lo_phase_e phase;
    leg_word_t cos_mix, sin_mix;
    leg_word_t cos_out, sin_out;

    mix4_phase_track u_phase (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .sync      (sync),
        .cur_phase (phase)
    );

    mix4_sign_leg #(.KIND(LEG_COS)) u_leg_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sample   (lane_a),
        .phase    (phase),
        .out_w    (cos_mix)
    );

    mix4_sign_leg #(.KIND(LEG_SIN)) u_leg_q (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sample   (lane_b),
        .phase    (phase),
        .out_w    (sin_mix)
    );

    mix4_align_delay #(.DEPTH(ALIGN_D)) u_dly_i (
        .clk  (clk),
        .rst  (rst),
        .din  (cos_mix),
        .dout (cos_out)
    );

    mix4_align_delay #(.DEPTH(ALIGN_D)) u_dly_q (
        .clk  (clk),
        .rst  (rst),
        .din  (sin_mix),
        .dout (sin_out)
    );

    assign i_valid = cos_out.vld;
    assign i_data  = cos_out.dat;
    assign q_valid = sin_out.vld;
    assign q_data  = sin_out.dat;

    // R8: the two legs leave in lock-step
    a_r8_legs_aligned: assert property (@(posedge clk) disable iff (rst)
        i_valid == q_valid);

endmodule

// File: tb/tb_mix4_quad_downmix.sv
module tb_mix4_quad_downmix;

    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic sync = 1'b0;
    logic signed [15:0] lane_a = '0;
    logic signed [15:0] lane_b = '0;
    logic i_valid, q_valid;
    logic signed [15:0] i_data, q_data;

    mix4_quad_downmix #(.LATENCY(LAT)) dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sync     (sync),
        .lane_a   (lane_a),
        .lane_b   (lane_b),
        .i_valid  (i_valid),
        .i_data   (i_data),
        .q_valid  (q_valid),
        .q_data   (q_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit    v;
        int    i;
        int    q;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0;
    int    errors = 0;
    bit    mph = 1'b0;
    bit    cur_v = 1'b0;
    bit    cur_s = 1'b0;
    int    cur_a = 0;
    int    cur_b = 0;
    string cur_tag = "R1";

    function automatic int nsat(int x);
        return (x == -32768) ? 32767 : -x;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(bit v, bit s, int a, int b, string tag);
        exp_t e;
        exp_t f;
        bit   cph;
        @(negedge clk);
        // reference: the word applied last cycle was captured at the edge just passed
        cph   = cur_s ? 1'b0 : mph;
        e.v   = cur_v;
        e.i   = cur_v ? (cph ? nsat(cur_a) : cur_a) : 0;
        e.q   = cur_v ? (cph ? cur_b : nsat(cur_b)) : 0;
        e.tag = cur_tag;
        mph   = cur_v ? ~cph : cph;
        expq.push_back(e);
        f = expq.pop_front();
        chk(i_valid == f.v, "R7", "i_valid", int'(i_valid), int'(f.v));
        chk(q_valid == i_valid, "R8", "q_valid", int'(q_valid), int'(i_valid));
        chk(i_data == f.i, f.tag, "i_data", int'(i_data), f.i);
        chk(q_data == f.q, f.tag, "q_data", int'(q_data), f.q);
        in_valid = v;
        sync     = s;
        lane_a   = 16'(a);
        lane_b   = 16'(b);
        cur_v    = v;
        cur_s    = s;
        cur_a    = a;
        cur_b    = b;
        cur_tag  = tag;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t z;
        z.v = 1'b0; z.i = 0; z.q = 0; z.tag = "R1";
        // R1: reset state, driving nonzero lanes to make sure nothing leaks
        lane_a = 16'sd1234;
        lane_b = -16'sd77;
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(i_valid == 1'b0 && q_valid == 1'b0, "R1", "valids in reset", int'({i_valid, q_valid}), 0);
        chk(i_data == 0 && q_data == 0, "R1", "data in reset", int'(i_data), 0);
        in_valid = 1'b0;
        lane_a = '0;
        lane_b = '0;
        rst = 1'b0;
        for (int k = 0; k < LAT - 1; k++) expq.push_back(z);

        // R2 R3 R4: steady stream, phase alternates
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 100 + k, -(200 + k), "R2 R3 R4");
        // R4 R9: gaps with junk on the lanes
        for (int k = 0; k < 12; k++) step(k % 3 != 0, 1'b0, 300 + k, 500 - k, "R4 R9");
        // R5: sync after odd and even run lengths
        step(1'b1, 1'b0, 11, 12, "R5");
        step(1'b1, 1'b1, 13, 14, "R5");
        step(1'b1, 1'b0, 15, 16, "R5");
        step(1'b1, 1'b1, 17, 18, "R5");
        step(1'b1, 1'b1, 19, 20, "R5");
        // R5: sync without valid, then a valid word must be at phase 0
        step(1'b1, 1'b0, 21, 22, "R5");
        step(1'b0, 1'b1, 23, 24, "R5 R9");
        step(1'b1, 1'b0, 25, 26, "R5");
        step(1'b1, 1'b0, 27, 28, "R5");
        // R6: most negative value in both phases on both lanes
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, -32768, -32768, "R6");
        step(1'b1, 1'b1, -32768, 32767, "R6");
        step(1'b1, 1'b0, 32767, -32768, "R6");
        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) != 0, ($urandom % 9) == 0,
                 int'($urandom_range(65535)) - 32768,
                 int'($urandom_range(65535)) - 32768, "R2 R3 R5");
        end
        // R9: drain with idle cycles
        for (int k = 0; k < LAT + 2; k++) step(1'b0, 1'b0, 999, -999, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule